// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block holds the configuration and address registers for eight memory protection entries of a 32-bit hart. Software reaches it through a plain CSR port: a 12-bit register number, 32 bits of write data and a write strobe. Reads are combinational, so the value comes back in the same cycle. The current settings of every entry are driven out in parallel, so that the access-checking logic next to the block can use them.

Every write is made legal before it is stored. Each entry has a lock bit. Once the lock is set, that entry's configuration byte and its address register are frozen until reset. The reserved permission pair (write allowed, read denied) is never stored. The upper half of the index space belongs to entries that are not implemented: it reads as zero and drops every write. Because a lock blocks all later writes to its entry, the final contents depend on the order in which writes arrive.

Top module: `pmp_csr_bank`

## Requirements
- R1: Configuration register k is at CSR number 0x3A0+k and holds entries 4k..4k+3. Entry i sits in bits [8*(i%4)+7 : 8*(i%4)] of register i/4. The address register of entry i is at 0x3B0+i. A read returns the stored value combinationally in the same cycle.
- R2: CSR numbers 0x3A2, 0x3A3 and 0x3B8..0x3BF always read zero, and writes to them change no state.
- R3: Layout of an entry byte: bit 0 read (R), bit 1 write (W), bit 2 execute (X), bits 4:3 match mode, bits 6:5 reserved, bit 7 lock (L). Bits 6:5 are always stored and read as zero.
- R4: While an entry's stored L bit is 1, writes to its configuration byte and to its address register are ignored until reset.
- R5: When a written byte has R=0 and W=1, the entry keeps its previous R and W bits. X, the match mode and L still take the written values, and R=0/W=1 is never stored.
- R6: Locking is decided per byte within one configuration write: unlocked entries in the same word take the new data, and locked ones keep theirs.
- R7: A synchronous active-high reset clears every configuration byte, every address register and every lock.
- R8: A write to a CSR number outside 0x3A0..0x3A3 and 0x3B0..0x3BF changes no state, and such a read returns zero.
- R9: `entry_cfg_o` and `entry_addr_o` show the stored value of every entry from the clock edge that performs the write.
- R10: A write that sets L stores the other fields of the same byte together with L. Only later writes are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR number for the read or write |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write strobe |
| csr_rdata | output | 32 | Read data, combinational |
| entry_cfg_o | output | 64 | Configuration bytes, entry i at [8i+7:8i] |
| entry_addr_o | output | 256 | Address registers, entry i at [32i+31:32i] |

## Verification
The hardest state to reach is a configuration word that mixes locked and unlocked entries while the reserved permission pair is written into it. That state needs a set order of writes: first give an entry known R/W bits, then lock one neighbour, then write a word that both sets L on another byte and carries R=0/W=1. The bench builds that sequence on purpose. It then runs a pseudo-random write stream in which locks gather over time. A reference model is compared against the entry outputs on every clock throughout.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;
  localparam int BIT_R  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_X  = 2;
  localparam int MODE_LO = 3;
  localparam int MODE_HI = 4;
  localparam int BIT_L  = 7;

  // Legal value for a written byte: drop the reserved bits and hold the
  // old R/W pair when the new one is the reserved R=0/W=1 combination.
  function automatic logic [7:0] cfg_legalize(input logic [7:0] old_b,
                                              input logic [7:0] new_b);
    logic [1:0] rw;
    rw = (new_b[BIT_W] && !new_b[BIT_R]) ? old_b[BIT_W:BIT_R] : new_b[BIT_W:BIT_R];
    return {new_b[BIT_L], 2'b00, new_b[MODE_HI:MODE_LO], new_b[BIT_X], rw};
  endfunction
endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode #(
  parameter int CSR_AW = 12,
  parameter logic [CSR_AW-1:0] CFG_BASE  = 12'h3A0,
  parameter logic [CSR_AW-1:0] ADDR_BASE = 12'h3B0,
  parameter int CFG_IW = 2,
  parameter int ADDR_IW = 4,
  parameter int NUM_CFG_IMPL = 2,
  parameter int NUM_ENTRIES = 8
) (
  input  logic [CSR_AW-1:0]  addr_i,
  output logic               cfg_hit_o,
  output logic               cfg_impl_o,
  output logic [CFG_IW-1:0]  cfg_idx_o,
  output logic               addr_hit_o,
  output logic               addr_impl_o,
  output logic [ADDR_IW-1:0] addr_idx_o
);
  // Both windows are aligned to their size, so a prefix compare suffices.
  assign cfg_hit_o   = addr_i[CSR_AW-1:CFG_IW]  == CFG_BASE[CSR_AW-1:CFG_IW];
  assign addr_hit_o  = addr_i[CSR_AW-1:ADDR_IW] == ADDR_BASE[CSR_AW-1:ADDR_IW];
  assign cfg_idx_o   = addr_i[CFG_IW-1:0];
  assign addr_idx_o  = addr_i[ADDR_IW-1:0];
  assign cfg_impl_o  = {1'b0, cfg_idx_o}  < (CFG_IW+1)'(NUM_CFG_IMPL);
  assign addr_impl_o = {1'b0, addr_idx_o} < (ADDR_IW+1)'(NUM_ENTRIES);
endmodule

// File: rtl/pmp_cfg_entry.sv
module pmp_cfg_entry
  import pmp_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] cfg_o
);
  logic [7:0] cfg_q;
  logic       locked;

  assign locked = cfg_q[BIT_L];

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (we_i && !locked)
      cfg_q <= cfg_legalize(cfg_q, wbyte_i);
  end

  assign cfg_o = cfg_q;

  AST_CFG_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg_q)); // R4
  AST_NO_RESERVED_RW: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q[BIT_W] && !cfg_q[BIT_R])); // R5
  AST_RSVD_RW_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (we_i && !locked && wbyte_i[BIT_W] && !wbyte_i[BIT_R])
      |=> cfg_q[BIT_W:BIT_R] == $past(cfg_q[BIT_W:BIT_R])); // R5
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_q[6:5] == 2'b00); // R3
endmodule

// File: rtl/pmp_addr_entry.sv
module pmp_addr_entry #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic            lock_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] addr_o
);
  logic [XLEN-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (we_i && !lock_i)
      addr_q <= wdata_i;
  end

  assign addr_o = addr_q;

  AST_ADDR_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> $stable(addr_q)); // R4
endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_bank_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_ENTRIES = 8,
  parameter int CSR_AW = 12,
  parameter logic [CSR_AW-1:0] CFG_BASE  = 12'h3A0,
  parameter logic [CSR_AW-1:0] ADDR_BASE = 12'h3B0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CSR_AW-1:0]           csr_addr,
  input  logic [XLEN-1:0]             csr_wdata,
  input  logic                        csr_we,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [NUM_ENTRIES*8-1:0]    entry_cfg_o,
  output logic [NUM_ENTRIES*XLEN-1:0] entry_addr_o
);
  localparam int BPC          = XLEN / 8;
  localparam int MAX_ENTRIES  = 16;
  localparam int MAX_CFG      = MAX_ENTRIES / BPC;
  localparam int CFG_IW       = $clog2(MAX_CFG);
  localparam int ADDR_IW      = $clog2(MAX_ENTRIES);
  localparam int NUM_CFG_IMPL = (NUM_ENTRIES + BPC - 1) / BPC;

  logic               cfg_hit, cfg_impl, addr_hit, addr_impl;
  logic [CFG_IW-1:0]  cfg_idx;
  logic [ADDR_IW-1:0] addr_idx;
  logic [NUM_ENTRIES-1:0] cfg_we, addr_we;
  logic [7:0]      cfg_q  [NUM_ENTRIES];
  logic [XLEN-1:0] addr_q [NUM_ENTRIES];

  pmp_csr_decode #(
    .CSR_AW(CSR_AW), .CFG_BASE(CFG_BASE), .ADDR_BASE(ADDR_BASE),
    .CFG_IW(CFG_IW), .ADDR_IW(ADDR_IW),
    .NUM_CFG_IMPL(NUM_CFG_IMPL), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dec (
    .addr_i(csr_addr),
    .cfg_hit_o(cfg_hit), .cfg_impl_o(cfg_impl), .cfg_idx_o(cfg_idx),
    .addr_hit_o(addr_hit), .addr_impl_o(addr_impl), .addr_idx_o(addr_idx)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    localparam int CR = i / BPC;
    localparam int BY = i % BPC;

    assign cfg_we[i]  = csr_we && cfg_hit && cfg_impl && (cfg_idx == CFG_IW'(CR));
    assign addr_we[i] = csr_we && addr_hit && addr_impl && (addr_idx == ADDR_IW'(i));

    pmp_cfg_entry u_cfg (
      .clk(clk), .rst(rst), .we_i(cfg_we[i]),
      .wbyte_i(csr_wdata[8*BY +: 8]), .cfg_o(cfg_q[i])
    );

    pmp_addr_entry #(.XLEN(XLEN)) u_addr (
      .clk(clk), .rst(rst), .we_i(addr_we[i]), .lock_i(cfg_q[i][BIT_L]),
      .wdata_i(csr_wdata), .addr_o(addr_q[i])
    );

    assign entry_cfg_o[8*i +: 8]       = cfg_q[i];
    assign entry_addr_o[XLEN*i +: XLEN] = addr_q[i];
  end

  // Combinational read path; unimplemented and unknown numbers give zero.
  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (cfg_hit && cfg_impl && (cfg_idx == CFG_IW'(i / BPC)))
        csr_rdata[8*(i % BPC) +: 8] = cfg_q[i];
      if (addr_hit && addr_impl && (addr_idx == ADDR_IW'(i)))
        csr_rdata = addr_q[i];
    end
  end

  AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((cfg_hit && !cfg_impl) || (addr_hit && !addr_impl)) |-> csr_rdata == '0); // R2
  AST_STRAY_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (csr_we && !(cfg_hit && cfg_impl) && !(addr_hit && addr_impl))
      |=> ($stable(entry_cfg_o) && $stable(entry_addr_o))); // R8
  AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hit && !addr_hit) |-> csr_rdata == '0); // R8
endmodule

// File: tb/pmp_csr_bank_test.sv
module pmp_csr_bank_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  csr_addr = '0;
  logic [31:0]  csr_wdata = '0;
  logic         csr_we = 1'b0;
  logic [31:0]  csr_rdata;
  logic [63:0]  entry_cfg_o;
  logic [255:0] entry_addr_o;

  int checks = 0;
  int errors = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  // Reference state (16 slots; only the first 8 are real)
  logic [7:0]  m_cfg  [16];
  logic [31:0] m_addr [16];

  pmp_csr_bank uut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata),
    .entry_cfg_o(entry_cfg_o), .entry_addr_o(entry_addr_o)
  );

  always #10 clk = ~clk;

  function automatic void model_clear();
    for (int i = 0; i < 16; i++) begin
      m_cfg[i] = 8'h00;
      m_addr[i] = 32'h0;
    end
  endfunction

  function automatic void model_write(logic [11:0] a, logic [31:0] d);
    if (a >= 12'h3A0 && a <= 12'h3A3) begin
      int k = int'(a) - 'h3A0;
      if (k < 2) begin
        for (int b = 0; b < 4; b++) begin
          int e = 4 * k + b;
          logic [7:0] nb = d[8*b +: 8];
          logic [1:0] keep;
          if (m_cfg[e][7] == 1'b0) begin
            keep = (nb[1:0] == 2'b10) ? m_cfg[e][1:0] : nb[1:0];
            m_cfg[e] = {nb[7], 2'b00, nb[4:2], keep};
          end
        end
      end
    end else if (a >= 12'h3B0 && a <= 12'h3BF) begin
      int e = int'(a) - 'h3B0;
      if (e < 8 && m_cfg[e][7] == 1'b0) m_addr[e] = d;
    end
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] r = 32'h0;
    if (a >= 12'h3A0 && a <= 12'h3A1) begin
      int k = int'(a) - 'h3A0;
      r = {m_cfg[4*k+3], m_cfg[4*k+2], m_cfg[4*k+1], m_cfg[4*k]};
    end else if (a >= 12'h3B0 && a <= 12'h3B7) begin
      r = m_addr[int'(a) - 'h3B0];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every clock: parallel outputs against the model (R9)
  always @(negedge clk) begin
    if (compare_on && !rst) begin
      logic [63:0] ec;
      logic [255:0] ea;
      for (int i = 0; i < 8; i++) begin
        ec[8*i +: 8] = m_cfg[i];
        ea[32*i +: 32] = m_addr[i];
      end
      chk("R9 entry_cfg_o", {192'h0, entry_cfg_o}, {192'h0, ec});
      chk("R9 entry_addr_o", entry_addr_o, ea);
    end
  end

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    csr_addr = a; csr_we = 1'b0;
    #2;
    chk(req, {224'h0, csr_rdata}, {224'h0, exp});
    chk({req, " model"}, {224'h0, csr_rdata}, {224'h0, model_read(a)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; csr_we = 1'b0;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    model_clear();
    repeat (3) @(posedge clk);
    do_reset();
    compare_on = 1'b1;

    // R7: everything zero after reset
    rd("R7 cfg0 after reset", 12'h3A0, 32'h0);
    rd("R7 cfg1 after reset", 12'h3A1, 32'h0);
    rd("R7 addr7 after reset", 12'h3B7, 32'h0);

    // R1/R3: packing, field layout, reserved bits 6:5 dropped
    do_write(12'h3A0, 32'h7F1B_0D03);
    rd("R1 R3 cfg0 packing", 12'h3A0, 32'h1F1B_0D03);
    for (int i = 0; i < 8; i++) do_write(12'h3B0 + 12'(i), 32'h1000_0000 + 32'(i) * 32'h111);
    rd("R1 addr0", 12'h3B0, 32'h1000_0000);
    rd("R1 addr6", 12'h3B6, 32'h1000_0666);

    // R2: unimplemented entries
    do_write(12'h3A2, 32'hFFFF_FFFF);
    do_write(12'h3A3, 32'hFFFF_FFFF);
    for (int i = 8; i < 16; i++) do_write(12'h3B0 + 12'(i), 32'hFFFF_FFFF);
    rd("R2 cfg2 reads zero", 12'h3A2, 32'h0);
    rd("R2 cfg3 reads zero", 12'h3A3, 32'h0);
    rd("R2 addr8 reads zero", 12'h3B8, 32'h0);
    rd("R2 addr15 reads zero", 12'h3BF, 32'h0);
    rd("R2 cfg0 untouched", 12'h3A0, 32'h1F1B_0D03);

    // R5: reserved R=0/W=1 keeps old R/W, other fields take new data
    do_write(12'h3A0, 32'h0202_0202);
    rd("R5 reserved rw keeps old", 12'h3A0, 32'h0303_0103);

    // R10: lock set together with fields stores them
    do_write(12'h3A1, 32'h0000_9F00);
    rd("R10 lock write stores fields", 12'h3A1, 32'h0000_9F00);
    // R6/R4: entry 5 locked, neighbours still update
    do_write(12'h3A1, 32'h1111_0711);
    rd("R6 per-byte lock", 12'h3A1, 32'h1111_9F11);
    do_write(12'h3B5, 32'hDEAD_BEEF);
    rd("R4 locked addr ignores write", 12'h3B5, 32'h1000_0555);
    do_write(12'h3B4, 32'hCAFE_F00D);
    rd("R4 unlocked addr takes write", 12'h3B4, 32'hCAFE_F00D);
    // R5 combined with lock on entry 6
    do_write(12'h3A1, 32'h118A_9F11);
    rd("R5 R10 reserved rw with lock", 12'h3A1, 32'h1189_9F11);
    do_write(12'h3A1, 32'h0000_0000);
    rd("R4 locked bytes hold", 12'h3A1, 32'h0089_9F00);

    // R8: stray numbers
    do_write(12'h3C0, 32'hFFFF_FFFF);
    do_write(12'h39F, 32'hFFFF_FFFF);
    rd("R8 stray read zero", 12'h3C0, 32'h0);
    rd("R8 cfg0 untouched", 12'h3A0, 32'h0303_0103);

    // Pseudo-random stream against the model (R9 every clock)
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 300; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[4] ? (12'h3B0 + {8'h0, lfsr[3:0]}) : (12'h3A0 + {10'h0, lfsr[1:0]});
      d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      if (lfsr[7:5] != 3'b000) d = d & 32'h7F7F_7F7F;
      do_write(a, d);
    end
    for (int i = 0; i < 4; i++) rd("R1 random cfg", 12'h3A0 + 12'(i), model_read(12'h3A0 + 12'(i)));
    for (int i = 0; i < 16; i++) rd("R1 random addr", 12'h3B0 + 12'(i), model_read(12'h3B0 + 12'(i)));

    // R7: reset clears state and releases locks
    do_reset();
    rd("R7 cfg1 cleared", 12'h3A1, 32'h0);
    rd("R7 addr4 cleared", 12'h3B4, 32'h0);
    do_write(12'h3B5, 32'h0000_1234);
    rd("R7 lock released", 12'h3B5, 32'h0000_1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule